// File: doc/BRIEF.md
# Register Programming Command Sequencer

This block is a small command engine. It fetches 32-bit command words from a memory read port and carries them out against a register-file port. It is built for chip-level register programming without software involvement. Two tasks share the engine. Each task has its own start address, its own timeout value and its own status flags. A task is started by a pulse and stops at a stop command or at an error.

The commands fall into three groups. The first waits on an external condition vector or tests it (pause, late check, interrupt). The second moves data between memory and registers (block load, single store). The third is a read-modify-write of one register under a bit mask. Memory uses a request/valid handshake for reads and a one-cycle write strobe. The register file is read combinationally and written with a strobe.

Top module: `cmdseq`

## Requirements
- R1: After reset both task enables, all status flags, `mem_req_o`, `mem_we_o` and `reg_we_o` are 0.
- R2: A pulse on `start_i[t]` while task t is disabled loads its program counter from its base input, sets its enable and clears its four flags. The pulse is ignored while task t is enabled.
- R3: When both tasks are enabled, task 0 is served first. The engine changes task only between commands, so a task in progress (including a pause) is never interrupted.
- R4: Opcode 0000 (bits 31:28) clears the task's enable without setting any flag.
- R5: A condition command selects inputs with the mask in bits CW-1:0. Bit 27 = 1 means any selected input that is 1 satisfies it. Bit 27 = 0 means all selected inputs must be 1, and an empty mask is then true. Bit 26 inverts the combined result.
- R6: PAUSE (0010) holds the engine until its condition is true. Its wait counter starts at 0 on entry. When the condition is still false and the counter equals the task's timeout value, the task's timeout flag is set and execution continues with the next command.
- R7: CHECK_LATE (0011) never stalls. It sets the task's late flag when its condition is true.
- R8: INTERRUPT (0110) sets the task's interrupt flag when its condition is true.
- R9: Block load (1000) takes its payload count L from bits 23:16 (1 to 255) and its first register from bits RW-1:0. It writes the next L words to consecutive registers. L = 0 sets the error flag and stops the task.
- R10: Store (1010) takes its register from bits RW-1:0. It writes that register's value to the memory address given by the following word.
- R11: Masked load (1100) names a register in bits RW-1:0 and is followed by a mask word and a value word. The register becomes (old & ~mask) | (value & mask).
- R12: Any other opcode sets the task's error flag and clears its enable. No further command of that task runs.
- R13: A memory request stays asserted with a stable address until `mem_rdata_i` is marked valid. A request and a write never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 2 | Per-task start pulse |
| base0_i | input | AW | Start address of task 0 |
| base1_i | input | AW | Start address of task 1 |
| tmo0_i | input | TW | Pause timeout of task 0 |
| tmo1_i | input | TW | Pause timeout of task 1 |
| cond_i | input | CW | External condition vector |
| mem_req_o | output | 1 | Read request |
| mem_we_o | output | 1 | Write strobe |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 32 | Write data |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | RW | Register address |
| reg_wdata_o | output | 32 | Register write data |
| reg_rdata_i | input | 32 | Register read data (combinational) |
| en_o | output | 2 | Per-task enable |
| late_o | output | 2 | Per-task late flag |
| irq_o | output | 2 | Per-task interrupt flag |
| tmo_o | output | 2 | Per-task timeout flag |
| err_o | output | 2 | Per-task error flag |

## Verification
The hardest case to reach is the hand-over between tasks at a command boundary. Task 0 must be started while task 1 sits inside a PAUSE. The bench also pulses task 1's start during that pause, with a different base address. It then releases the condition. Task 0 must finish before task 1's next command runs, and the ignored restart must leave no trace in task 1's flags. Condition combining is driven from a vector table that crosses the any/all and invert bits with full, partial and empty matches.

// File: rtl/cmdseq.sv
module cmdseq #(
  parameter int AW = 12,
  parameter int RW = 8,
  parameter int CW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    start_i,
  input  logic [AW-1:0] base0_i,
  input  logic [AW-1:0] base1_i,
  input  logic [TW-1:0] tmo0_i,
  input  logic [TW-1:0] tmo1_i,
  input  logic [CW-1:0] cond_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_valid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          reg_we_o,
  output logic [RW-1:0] reg_addr_o,
  output logic [31:0]   reg_wdata_o,
  input  logic [31:0]   reg_rdata_i,
  output logic [1:0]    en_o,
  output logic [1:0]    late_o,
  output logic [1:0]    irq_o,
  output logic [1:0]    tmo_o,
  output logic [1:0]    err_o
);
  localparam logic [3:0] OP_STOP  = 4'b0000;
  localparam logic [3:0] OP_PAUSE = 4'b0010;
  localparam logic [3:0] OP_LATE  = 4'b0011;
  localparam logic [3:0] OP_INT   = 4'b0110;
  localparam logic [3:0] OP_LOAD  = 4'b1000;
  localparam logic [3:0] OP_STORE = 4'b1010;
  localparam logic [3:0] OP_MASK  = 4'b1100;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DEC, S_ARG, S_PAUSE, S_WR} st_t;

  st_t               state;
  logic              cur;
  logic [1:0][AW-1:0] pc;
  logic [31:0]       ir, aux;
  logic [RW-1:0]     raddr;
  logic [7:0]        left;
  logic [TW-1:0]     cnt;
  logic [1:0]        en, late, irq, tmo, err;

  wire [3:0]    op      = ir[31:28];
  wire [TW-1:0] tmo_cur = cur ? tmo1_i : tmo0_i;
  wire          unused_bits = ^{ir[25:24], ir[15:8]};

  function automatic logic cond_ok(input logic [31:0] w, input logic [CW-1:0] c);
    logic [CW-1:0] sel;
    logic hit;
    sel = w[CW-1:0];
    hit = w[27] ? |(c & sel) : &(c | ~sel);
    return hit ^ w[26];
  endfunction

  wire cok = cond_ok(ir, cond_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur   <= 1'b0;
      pc    <= '0;
      ir    <= '0;
      aux   <= '0;
      raddr <= '0;
      left  <= '0;
      cnt   <= '0;
      en    <= '0;
      late  <= '0;
      irq   <= '0;
      tmo   <= '0;
      err   <= '0;
    end else begin
      for (int t = 0; t < 2; t++) begin
        if (start_i[t] && !en[t]) begin
          pc[t]   <= (t == 0) ? base0_i : base1_i;
          en[t]   <= 1'b1;
          late[t] <= 1'b0;
          irq[t]  <= 1'b0;
          tmo[t]  <= 1'b0;
          err[t]  <= 1'b0;
        end
      end
      case (state)
        S_IDLE: begin
          if (en[0]) begin
            cur   <= 1'b0;
            state <= S_FETCH;
          end else if (en[1]) begin
            cur   <= 1'b1;
            state <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (mem_valid_i) begin
            ir      <= mem_rdata_i;
            pc[cur] <= pc[cur] + AW'(1);
            state   <= S_DEC;
          end
        end
        S_DEC: begin
          state <= S_IDLE;
          raddr <= ir[RW-1:0];
          case (op)
            OP_STOP:  en[cur] <= 1'b0;
            OP_PAUSE: begin
              cnt   <= '0;
              state <= S_PAUSE;
            end
            OP_LATE:  if (cok) late[cur] <= 1'b1;
            OP_INT:   if (cok) irq[cur] <= 1'b1;
            OP_LOAD: begin
              if (ir[23:16] == 8'd0) begin
                err[cur] <= 1'b1;
                en[cur]  <= 1'b0;
              end else begin
                left  <= ir[23:16];
                state <= S_ARG;
              end
            end
            OP_STORE: state <= S_ARG;
            OP_MASK: begin
              left  <= 8'd2;
              state <= S_ARG;
            end
            default: begin
              err[cur] <= 1'b1;
              en[cur]  <= 1'b0;
            end
          endcase
        end
        S_ARG: begin
          if (mem_valid_i) begin
            pc[cur] <= pc[cur] + AW'(1);
            if (op == OP_LOAD) begin
              raddr <= raddr + RW'(1);
              left  <= left - 8'd1;
              if (left == 8'd1) state <= S_IDLE;
            end else if (op == OP_STORE) begin
              aux   <= mem_rdata_i;
              state <= S_WR;
            end else begin
              if (left == 8'd2) begin
                aux  <= mem_rdata_i;
                left <= 8'd1;
              end else begin
                state <= S_IDLE;
              end
            end
          end
        end
        S_PAUSE: begin
          if (cok) begin
            state <= S_IDLE;
          end else if (cnt == tmo_cur) begin
            tmo[cur] <= 1'b1;
            state    <= S_IDLE;
          end else begin
            cnt <= cnt + TW'(1);
          end
        end
        S_WR:    state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state == S_FETCH) || (state == S_ARG);
  assign mem_we_o    = (state == S_WR);
  assign mem_addr_o  = (state == S_WR) ? aux[AW-1:0] : pc[cur];
  assign mem_wdata_o = reg_rdata_i;
  assign reg_addr_o  = raddr;
  assign reg_we_o    = (state == S_ARG) && mem_valid_i &&
                       ((op == OP_LOAD) || ((op == OP_MASK) && (left == 8'd1)));
  assign reg_wdata_o = (op == OP_MASK) ? ((reg_rdata_i & ~aux) | (mem_rdata_i & aux))
                                       : mem_rdata_i;
  assign en_o   = en;
  assign late_o = late;
  assign irq_o  = irq;
  assign tmo_o  = tmo;
  assign err_o  = err;

  a_r13_req_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_o && mem_we_o));
  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o));
  a_r9_we_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> mem_req_o && mem_valid_i);

  for (genvar g = 0; g < 2; g++) begin : g_chk
    a_r12_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o[g]) |-> !en_o[g]);
    a_r6_tmo_from_pause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_o[g]) |-> $past(state) == S_PAUSE);
    a_r7_late_from_dec: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(late_o[g]) |-> $past(state) == S_DEC && $past(op) == OP_LATE);
  end
endmodule

// File: tb/cmdseq_tb.sv
module cmdseq_tb_top;
  localparam int AW = 12, RW = 8, CW = 8, TW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] start_i = '0;
  logic [AW-1:0] base0_i = '0, base1_i = '0;
  logic [TW-1:0] tmo0_i = '0, tmo1_i = '0;
  logic [CW-1:0] cond_i = '0;
  logic mem_req_o, mem_we_o, mem_valid_i, reg_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i, reg_wdata_o, reg_rdata_i;
  logic [RW-1:0] reg_addr_o;
  logic [1:0] en_o, late_o, irq_o, tmo_o, err_o;

  logic [31:0] mem  [256];
  logic [31:0] regs [256];
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cmdseq #(.AW(AW), .RW(RW), .CW(CW), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .base0_i(base0_i), .base1_i(base1_i), .tmo0_i(tmo0_i), .tmo1_i(tmo1_i),
    .cond_i(cond_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i),
    .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .reg_rdata_i(reg_rdata_i), .en_o(en_o), .late_o(late_o), .irq_o(irq_o),
    .tmo_o(tmo_o), .err_o(err_o));

  initial mem_valid_i = 1'b0;
  initial mem_rdata_i = '0;
  always @(posedge clk) begin
    if (mem_req_o && !mem_valid_i) begin
      mem_valid_i <= 1'b1;
      mem_rdata_i <= mem[mem_addr_o[7:0]];
    end else begin
      mem_valid_i <= 1'b0;
    end
    if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
    if (reg_we_o) regs[reg_addr_o] <= reg_wdata_o;
  end
  assign reg_rdata_i = regs[reg_addr_o];

  // {expected irq, cond, INTERRUPT command word}
  localparam logic [40:0] VEC [9] = '{
    {1'b1, 8'h03, 32'h6000_0003},
    {1'b0, 8'h01, 32'h6000_0003},
    {1'b1, 8'h01, 32'h6800_0003},
    {1'b0, 8'h00, 32'h6800_0003},
    {1'b1, 8'h01, 32'h6400_0003},
    {1'b0, 8'h03, 32'h6400_0003},
    {1'b0, 8'h80, 32'h6C00_0080},
    {1'b1, 8'h00, 32'h6000_0000},
    {1'b0, 8'hF0, 32'h6800_000F}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse(input logic [1:0] s);
    @(negedge clk) start_i = s;
    @(negedge clk) start_i = '0;
  endtask

  task automatic wait_off(input int t, output int cyc);
    cyc = 0;
    while (en_o[t] && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run0(input logic [AW-1:0] base, output int cyc);
    base0_i = base;
    pulse(2'b01);
    wait_off(0, cyc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    for (int i = 0; i < 256; i++) begin
      mem[i]  <= '0;
      regs[i] <= '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 en", 32'(en_o), 0);
    chk("R1 req/we", 32'({mem_req_o, mem_we_o, reg_we_o}), 0);
    chk("R1 flags", 32'({late_o, irq_o, tmo_o, err_o}), 0);

    // R5 / R8 condition table
    for (int v = 0; v < 9; v++) begin
      mem[0] <= VEC[v][31:0];
      mem[1] <= 32'h0;
      cond_i = VEC[v][39:32];
      run0(12'h000, cyc);
      chk("R5 R8 irq vector", 32'(irq_o[0]), 32'(VEC[v][40]));
    end

    // R2 flags cleared on start, R4 stop sets nothing
    mem[8'h58] <= 32'h0;
    run0(12'h058, cyc);
    chk("R2 irq cleared by start", 32'(irq_o[0]), 0);
    chk("R4 stop no err", 32'({en_o[0], err_o[0], late_o[0], tmo_o[0]}), 0);

    // R6 pause stalls, then releases
    mem[8'h10] <= 32'h2000_0001;
    mem[8'h11] <= 32'h6000_0000;
    mem[8'h12] <= 32'h0;
    cond_i = '0;
    tmo0_i = 16'd200;
    base0_i = 12'h010;
    pulse(2'b01);
    repeat (30) @(negedge clk);
    chk("R6 stalled", 32'({en_o[0], irq_o[0]}), 32'b10);
    cond_i = 8'h01;
    wait_off(0, cyc);
    chk("R6 released no tmo", 32'({tmo_o[0], irq_o[0]}), 32'b01);

    // R6 timeout
    cond_i = '0;
    tmo0_i = 16'd5;
    run0(12'h010, cyc);
    chk("R6 timeout flag and continue", 32'({tmo_o[0], irq_o[0]}), 32'b11);

    // R7 late check
    mem[8'h20] <= 32'h3000_0004;
    mem[8'h21] <= 32'h0;
    cond_i = 8'h04;
    run0(12'h020, cyc);
    chk("R7 late set", 32'(late_o[0]), 1);
    chk("R7 no stall", 32'(cyc < 20), 1);
    cond_i = 8'h00;
    run0(12'h020, cyc);
    chk("R7 late clear", 32'(late_o[0]), 0);

    // R9 block load
    regs[8'h13] <= 32'h5555_5555;
    mem[8'h30] <= 32'h8003_0010;
    mem[8'h31] <= 32'hA1A1_0001;
    mem[8'h32] <= 32'hB2B2_0002;
    mem[8'h33] <= 32'hC3C3_0003;
    mem[8'h34] <= 32'h0;
    run0(12'h030, cyc);
    chk("R9 reg10", regs[8'h10], 32'hA1A1_0001);
    chk("R9 reg11", regs[8'h11], 32'hB2B2_0002);
    chk("R9 reg12", regs[8'h12], 32'hC3C3_0003);
    chk("R9 reg13 untouched", regs[8'h13], 32'h5555_5555);
    chk("R9 no err", 32'(err_o[0]), 0);

    // R9 zero length
    mem[8'h38] <= 32'h8000_0010;
    mem[8'h39] <= 32'h6000_0000;
    mem[8'h3A] <= 32'h0;
    run0(12'h038, cyc);
    chk("R9 len0 err/stop", 32'({err_o[0], irq_o[0], en_o[0]}), 32'b100);

    // R10 store
    mem[8'h40] <= 32'hA000_0011;
    mem[8'h41] <= 32'h0000_0080;
    mem[8'h42] <= 32'h0;
    run0(12'h040, cyc);
    chk("R10 stored word", mem[8'h80], 32'hB2B2_0002);

    // R11 masked load
    regs[8'h20] <= 32'hAAAA_AAAA;
    mem[8'h48] <= 32'hC000_0020;
    mem[8'h49] <= 32'h0000_FFFF;
    mem[8'h4A] <= 32'h1234_5678;
    mem[8'h4B] <= 32'h0;
    run0(12'h048, cyc);
    chk("R11 masked result", regs[8'h20], 32'hAAAA_5678);

    // R12 bad opcode
    mem[8'h50] <= 32'h5000_0000;
    mem[8'h51] <= 32'h6000_0000;
    mem[8'h52] <= 32'h0;
    run0(12'h050, cyc);
    chk("R12 err, no further cmd", 32'({err_o[0], irq_o[0], en_o[0]}), 32'b100);

    // R3 simultaneous start: task 0 fetched first
    mem[8'h68] <= 32'h6000_0000;
    mem[8'h69] <= 32'h0;
    mem[8'h78] <= 32'h6000_0000;
    mem[8'h79] <= 32'h0;
    base0_i = 12'h068;
    base1_i = 12'h078;
    pulse(2'b11);
    cyc = 0;
    while (!mem_req_o && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    chk("R3 first fetch is task 0", 32'(mem_addr_o), 32'h068);
    wait_off(0, cyc);
    wait_off(1, cyc);
    chk("R3 both ran", 32'(irq_o), 32'b11);

    // R3 boundary switch with R2 ignored restart
    mem[8'h60] <= 32'h2000_0002;
    mem[8'h61] <= 32'h6000_0000;
    mem[8'h62] <= 32'h0;
    mem[8'h70] <= 32'h3000_0000;
    mem[8'h71] <= 32'h0;
    cond_i = '0;
    tmo1_i = 16'd1000;
    base1_i = 12'h060;
    pulse(2'b10);
    repeat (10) @(negedge clk);
    base0_i = 12'h068;
    pulse(2'b01);
    base1_i = 12'h070;
    pulse(2'b10);
    repeat (20) @(negedge clk);
    chk("R3 task 0 waits for boundary", 32'({irq_o[0], en_o[0], en_o[1]}), 32'b011);
    cond_i = 8'h02;
    wait_off(0, cyc);
    chk("R3 task 0 before task 1 resumes", 32'({irq_o[0], irq_o[1]}), 32'b10);
    wait_off(1, cyc);
    chk("R2 restart ignored", 32'({irq_o[1], late_o[1], tmo_o[1]}), 32'b100);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule